// File: doc/BRIEF.md
# Bridge System Error Reporter

This block sits inside a two-bus bridge. It decides when the active-low system error output on the upstream (primary) side is driven. It gathers independent error sources:
- a downstream system error input;
- abort strobes seen while a posted write completes;
- a parity mismatch strobe pair;
- three retry watchdogs, one each for posted writes, delayed writes and delayed reads.

A global command enable gates every source. A separate forwarding enable gates only the downstream input.

Each watchdog counts target retries for the transaction in flight. It clears when the transaction completes. When the count reaches a parameterised limit (2^24 by default), the watchdog emits a single-cycle discard pulse and then saturates. Two sticky status bits record errors: one for a system error received from downstream, one for a system error signalled upstream. Each clears when its write-1-to-clear strobe is pulsed. All interfaces are plain level or pulse signals, so there is no stream handshake and no back-pressure.

Top module: `bridge_serr_reporter`

## Requirements
- R1: After reset, `pri_serr_n` is 1, both status bits are 0 and `discard` is 0.
- R2: When `cmd_serr_en` is 0 at a clock edge, `pri_serr_n` is 1 after that edge, whatever the sources do.
- R3: Every clock edge that drives `pri_serr_n` low also sets `sig_serr_sts` at that same edge.
- R4: When `sec_serr_n` goes from 1 to 0 between two edges, and both `cmd_serr_en` and `fwd_serr_en` are 1, `pri_serr_n` is 0 for the following cycle. If `fwd_serr_en` is 0, that transition raises nothing.
- R5: A 1-to-0 transition of `sec_serr_n` sets `rcv_serr_sts` at the edge where the 0 is first sampled, regardless of either enable.
- R6: A `pw_tabort` or `pw_mabort` pulse sampled with `cmd_serr_en` set drives `pri_serr_n` low after that edge.
- R7: A `pw_par_tgt` pulse without `pw_par_init` drives `pri_serr_n` low after the edge. If both are high together, nothing is raised.
- R8: Bit 0 of `txn_retry`, `txn_done` and `discard` is the posted write, bit 1 the delayed write and bit 2 the delayed read. The RETRY_LIMIT-th retry counted since the last `txn_done` sets that `discard` bit for exactly one cycle, after the same edge. Further retries produce no pulse until the next `txn_done`.
- R9: `txn_done` clears its counter and takes priority over a simultaneous retry.
- R10: A `discard` pulse with `cmd_serr_en` set drives `pri_serr_n` low for the following cycle.
- R11: The output is low for one cycle per qualifying event. Holding `sec_serr_n` low does not repeat it.
- R12: `clr_sig_sts` and `clr_rcv_sts` clear their bit at the edge. A set at the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_serr_n | input | 1 | Downstream system error, active low |
| pw_tabort | input | 1 | Target abort during a posted write (pulse) |
| pw_mabort | input | 1 | Master abort during a posted write (pulse) |
| pw_par_tgt | input | 1 | Parity error reported on the target bus during a posted write |
| pw_par_init | input | 1 | Parity error also seen on the initiator bus |
| txn_retry | input | 3 | Target retry strobe per transaction type |
| txn_done | input | 3 | Completion strobe per transaction type |
| cmd_serr_en | input | 1 | Global system error enable |
| fwd_serr_en | input | 1 | Downstream error forwarding enable |
| clr_sig_sts | input | 1 | Write-1-to-clear strobe for the signalled bit |
| clr_rcv_sts | input | 1 | Write-1-to-clear strobe for the received bit |
| pri_serr_n | output | 1 | Upstream system error, active low |
| sig_serr_sts | output | 1 | Sticky: a system error was signalled |
| rcv_serr_sts | output | 1 | Sticky: a downstream system error was received |
| discard | output | 3 | Single-cycle discard pulse per transaction type |

## Verification
The bench targets four behaviours:
- A completion in the same cycle as the limit-reaching retry. A design that gave the retry priority would discard a transaction that had finished.
- A downstream error held low for many cycles. An edge-blind design would assert the output on every cycle the input stays low.
- A clear strobe arriving together with a new event. A design where the clear wins would lose that record.
- Parity errors flagged on both buses at once, and every source with the global enable off. A design that ignored either gating would raise spurious upstream errors.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int NUM_TXN = 3;
  typedef enum logic [1:0] {
    TXN_POSTED_WR  = 2'd0,
    TXN_DELAYED_WR = 2'd1,
    TXN_DELAYED_RD = 2'd2
  } txn_kind_e;
endpackage

// File: rtl/serr_retry_watch.sv
module serr_retry_watch #(
  parameter int unsigned LIMIT = 32'd16777216
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retry,
  input  logic done,
  output logic discard
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      discard <= 1'b0;
    end else begin
      discard <= retry && !done && (cnt_q == LIM_M1);
      if (done)
        cnt_q <= '0;
      else if (retry && cnt_q != LIM)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/serr_sec_edge.sv
module serr_sec_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_serr_n,
  output logic sec_fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sec_serr_n;
  end

  assign sec_fall = prev_q & ~sec_serr_n;
endmodule

// File: rtl/serr_gate.sv
module serr_gate #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_en,
  input  logic         fwd_en,
  input  logic         sec_fall,
  input  logic         tabort,
  input  logic         mabort,
  input  logic         par_tgt,
  input  logic         par_init,
  input  logic [N-1:0] disc,
  input  logic         clr_sig,
  input  logic         clr_rcv,
  output logic         serr_n,
  output logic         sig_sts,
  output logic         rcv_sts
);
  logic local_ev, fwd_ev, fire;

  assign local_ev = tabort | mabort | (par_tgt & ~par_init) | (|disc);
  assign fwd_ev   = sec_fall & fwd_en;
  assign fire     = cmd_en & (local_ev | fwd_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_n  <= 1'b1;
      sig_sts <= 1'b0;
      rcv_sts <= 1'b0;
    end else begin
      serr_n  <= ~fire;
      sig_sts <= fire | (sig_sts & ~clr_sig);
      rcv_sts <= sec_fall | (rcv_sts & ~clr_rcv);
    end
  end
endmodule

// File: rtl/bridge_serr_reporter.sv
module bridge_serr_reporter
  import serr_pkg::*;
#(
  parameter int unsigned RETRY_LIMIT = 32'd16777216
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_serr_n,
  input  logic               pw_tabort,
  input  logic               pw_mabort,
  input  logic               pw_par_tgt,
  input  logic               pw_par_init,
  input  logic [NUM_TXN-1:0] txn_retry,
  input  logic [NUM_TXN-1:0] txn_done,
  input  logic               cmd_serr_en,
  input  logic               fwd_serr_en,
  input  logic               clr_sig_sts,
  input  logic               clr_rcv_sts,
  output logic               pri_serr_n,
  output logic               sig_serr_sts,
  output logic               rcv_serr_sts,
  output logic [NUM_TXN-1:0] discard
);
  logic sec_fall;

  for (genvar t = 0; t < NUM_TXN; t++) begin : g_watch
    serr_retry_watch #(.LIMIT(RETRY_LIMIT)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .retry   (txn_retry[t]),
      .done    (txn_done[t]),
      .discard (discard[t])
    );
  end

  serr_sec_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_serr_n (sec_serr_n),
    .sec_fall   (sec_fall)
  );

  serr_gate #(.N(NUM_TXN)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (cmd_serr_en),
    .fwd_en   (fwd_serr_en),
    .sec_fall (sec_fall),
    .tabort   (pw_tabort),
    .mabort   (pw_mabort),
    .par_tgt  (pw_par_tgt),
    .par_init (pw_par_init),
    .disc     (discard),
    .clr_sig  (clr_sig_sts),
    .clr_rcv  (clr_rcv_sts),
    .serr_n   (pri_serr_n),
    .sig_sts  (sig_serr_sts),
    .rcv_sts  (rcv_serr_sts)
  );
endmodule

// File: rtl/serr_checker.sv
module serr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_serr_en,
  input logic       pw_tabort,
  input logic       pw_par_tgt,
  input logic       pw_par_init,
  input logic       pri_serr_n,
  input logic       sig_serr_sts,
  input logic [2:0] discard
);
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_serr_en |=> pri_serr_n); // R2
  AST_SIG_WITH_SERR: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> sig_serr_sts); // R3
  AST_TABORT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && pw_tabort) |=> !pri_serr_n); // R6
  AST_PARITY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && pw_par_tgt && !pw_par_init) |=> !pri_serr_n); // R7
  AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (discard & $past(discard)) == 3'b000); // R8
  AST_DISCARD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && (|discard)) |=> !pri_serr_n); // R10
endmodule

bind bridge_serr_reporter serr_checker u_serr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_serr_en  (cmd_serr_en),
  .pw_tabort    (pw_tabort),
  .pw_par_tgt   (pw_par_tgt),
  .pw_par_init  (pw_par_init),
  .pri_serr_n   (pri_serr_n),
  .sig_serr_sts (sig_serr_sts),
  .discard      (discard)
);

// File: tb/test_bridge_serr_reporter.sv
module test_bridge_serr_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_serr_n = 1'b1, pw_tabort = 0, pw_mabort = 0, pw_par_tgt = 0, pw_par_init = 0;
  logic [2:0] txn_retry = '0, txn_done = '0;
  logic cmd_serr_en = 0, fwd_serr_en = 0, clr_sig_sts = 0, clr_rcv_sts = 0;
  logic pri_serr_n, sig_serr_sts, rcv_serr_sts;
  logic [2:0] discard;

  int errors = 0, checks = 0;

  // reference model state
  logic m_prev = 1'b1, m_serr_n = 1'b1, m_sig = 1'b0, m_rcv = 1'b0;
  logic [2:0] m_disc = '0;
  int m_cnt [3] = '{0, 0, 0};
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_serr_reporter #(.RETRY_LIMIT(LIM)) i_bridge_serr_reporter (
    .clk(clk), .rst_n(rst_n), .sec_serr_n(sec_serr_n), .pw_tabort(pw_tabort),
    .pw_mabort(pw_mabort), .pw_par_tgt(pw_par_tgt), .pw_par_init(pw_par_init),
    .txn_retry(txn_retry), .txn_done(txn_done), .cmd_serr_en(cmd_serr_en),
    .fwd_serr_en(fwd_serr_en), .clr_sig_sts(clr_sig_sts), .clr_rcv_sts(clr_rcv_sts),
    .pri_serr_n(pri_serr_n), .sig_serr_sts(sig_serr_sts), .rcv_serr_sts(rcv_serr_sts),
    .discard(discard));

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string serr_cause(logic fall);
    if (!cmd_serr_en) return "R2";
    if (|m_disc) return "R10";
    if (fall && fwd_serr_en) return "R4";
    if (pw_tabort || pw_mabort) return "R6";
    if (pw_par_tgt) return "R7";
    return "R11";
  endfunction

  task automatic model_edge();
    logic fall;
    logic [2:0] nd;
    logic ev;
    fall = m_prev && !sec_serr_n;
    m_prev = sec_serr_n;
    for (int t = 0; t < 3; t++) begin
      nd[t] = txn_retry[t] && !txn_done[t] && (m_cnt[t] == LIM - 1);
      if (txn_done[t]) m_cnt[t] = 0;
      else if (txn_retry[t] && m_cnt[t] < LIM) m_cnt[t]++;
    end
    ev = (fall && fwd_serr_en) || pw_tabort || pw_mabort ||
         (pw_par_tgt && !pw_par_init) || (|m_disc);
    m_tag = serr_cause(fall);
    m_serr_n = !(cmd_serr_en && ev);
    m_sig = !m_serr_n || (m_sig && !clr_sig_sts);
    m_rcv = fall || (m_rcv && !clr_rcv_sts);
    m_disc = nd;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({2'b0, pri_serr_n}, {2'b0, m_serr_n}, m_tag);
    chk({2'b0, sig_serr_sts}, {2'b0, m_sig}, m_sig ? "R3" : "R12");
    chk({2'b0, rcv_serr_sts}, {2'b0, m_rcv}, "R5");
    chk(discard, m_disc, "R8");
  endtask

  task automatic idle();
    pw_tabort = 0; pw_mabort = 0; pw_par_tgt = 0; pw_par_init = 0;
    txn_retry = '0; txn_done = '0; clr_sig_sts = 0; clr_rcv_sts = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({pri_serr_n, sig_serr_sts, rcv_serr_sts}, 3'b100, "R1");
    chk(discard, 3'b000, "R1");
    rst_n = 1'b1;
    cmd_serr_en = 1; fwd_serr_en = 1;

    // R9: completion in the limit cycle keeps the discard away
    for (int i = 0; i < LIM - 1; i++) begin txn_retry = 3'b001; step(); end
    txn_done = 3'b001; step(); idle();
    chk(discard, 3'b000, "R9");
    for (int i = 0; i < LIM - 1; i++) begin txn_retry = 3'b001; step(); end
    chk(discard, 3'b000, "R9");
    step();
    chk(discard, 3'b001, "R8");
    idle(); step();
    chk({2'b0, pri_serr_n}, 3'b000, "R10");

    // R11: a held downstream error raises one pulse only
    sec_serr_n = 0; step();
    chk({2'b0, pri_serr_n}, 3'b000, "R4");
    repeat (3) begin step(); chk({2'b0, pri_serr_n}, 3'b001, "R11"); end
    sec_serr_n = 1; fwd_serr_en = 0; step();
    sec_serr_n = 0; step();
    chk({2'b0, pri_serr_n}, 3'b001, "R4");
    sec_serr_n = 1;

    // R12: a set beats a clear in the same cycle
    pw_tabort = 1; clr_sig_sts = 1; step(); idle();
    chk({2'b0, sig_serr_sts}, 3'b001, "R12");
    clr_sig_sts = 1; clr_rcv_sts = 1; step(); idle();
    chk({1'b0, sig_serr_sts, rcv_serr_sts}, 3'b000, "R12");

    // R7: parity seen on both buses is not reported
    pw_par_tgt = 1; pw_par_init = 1; step(); idle();
    chk({2'b0, pri_serr_n}, 3'b001, "R7");
    // R2: global enable off masks a master abort
    cmd_serr_en = 0; pw_mabort = 1; step(); idle();
    chk({2'b0, pri_serr_n}, 3'b001, "R2");
    cmd_serr_en = 1;

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        cmd_serr_en = ($urandom % 4) != 0;
        fwd_serr_en = $urandom % 2;
      end
      pw_tabort   = ($urandom % 20) == 0;
      pw_mabort   = ($urandom % 20) == 0;
      pw_par_tgt  = ($urandom % 15) == 0;
      pw_par_init = ($urandom % 3) == 0;
      for (int t = 0; t < 3; t++) begin
        txn_retry[t] = ($urandom % 2) == 0;
        txn_done[t]  = ($urandom % 14) == 0;
      end
      if (($urandom % 10) == 0) sec_serr_n = ~sec_serr_n;
      clr_sig_sts = ($urandom % 8) == 0;
      clr_rcv_sts = ($urandom % 8) == 0;
      step();
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule